// File: doc/BRIEF.md
# PTP Event Timestamp Queue with Word-Serial Readout

This block sits on one direction (transmit or receive) of one network port. Whenever the capture logic upstream sees a PTP event message, it presents a complete timestamp record on the capture inputs for one clock, together with a strobe. The record holds a 16-bit tag, whose low three bits give the message kind (1 Sync, 2 Pdelay_Req, 3 Pdelay_Resp, 4 Delay_Req), plus 48-bit seconds, 32-bit nanoseconds, a 64-bit clock identity, a 16-bit port number and a 16-bit sequence id. The block stores these records in a queue of up to `DEPTH` entries (90 by default). The block carries the record unchanged and does not decode the tag.

Software drains the queue one 16-bit word at a time through a single data register. It reads a status register to find out whether a record is waiting, where it is within the current record, how many records were lost, and whether capture is on. A per-record reader state machine has four states. OFF means capture is disabled. EMPTY means enabled with nothing queued. HEAD means a record is waiting and the next read returns its first word. MID means part of a record has been read. The transitions are EN_SET (OFF to EMPTY), DISABLE (any state to OFF), REC_ARRIVE (EMPTY to HEAD), FIRST_READ (HEAD to MID), NEXT_WORD (MID to MID), and LAST_READ (MID to HEAD when another record is left, or to EMPTY when none is).

Top module: `ptp_ts_fifo`

## Requirements
- R1: After reset, capture is disabled, the not-empty flag is low, and both the status register (address 0) and the data register (address 1) read 0.
- R2: A record leaves as twelve 16-bit words in this order: tag; seconds in 3 words, most significant first; nanoseconds in 2 words, most significant first; clock identity in 4 words, most significant first; port number; sequence id.
- R3: Status bits 12:8 hold the word position. It is 0 when the next data read returns a record's first word, it rises by one on each data read of a stored record, and after the twelfth word it returns to 0 and that record is removed.
- R4: The not-empty output is high exactly when at least one record is stored.
- R5: Status bit 15 is the capture enable, set or cleared by writing status. A strobe arriving while it is clear stores nothing.
- R6: The queue holds `DEPTH` records. A strobe that arrives while the queue is full drops that record and adds one to the discard count in status bits 7:4, which stops at 15. Fullness is judged before any removal in the same cycle.
- R7: A data read while no record is stored returns 0 and leaves the word position unchanged.
- R8: Writing status with bit 15 clear empties the queue and sets the word position and the discard count to 0, effective from the next cycle.
- R9: Writes to the data register have no effect. Status bits 14:13 and 3:0 read 0, and status reads change nothing.
- R10: Records are read out in the order they were captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_valid | input | 1 | One-cycle strobe: record fields are valid |
| cap_tag | input | 16 | Tag word, message kind in bits 2:0 |
| cap_sec | input | 48 | Seconds |
| cap_nsec | input | 32 | Nanoseconds |
| cap_clkid | input | 64 | Source clock identity |
| cap_port | input | 16 | Source port number |
| cap_seq | input | 16 | Sequence id |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 selects status, 1 selects data |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register, valid in the strobe cycle |
| fifo_not_empty | output | 1 | At least one record stored |

## Verification
The assertions assume the bus never issues a read and a write in the same cycle, and that `cap_valid` is a single-cycle strobe whose fields are stable in that cycle. The wrap and hold properties rely on this, because a disabling write in the same cycle would override the expected word position. The stimulus applies one bus operation per call and drives all inputs on the falling edge. A reference queue model in the bench predicts read data and the flag before every rising edge. It drives the queue to full and then beyond, makes a removal coincide with a capture while full, and disables capture partway through a record.

// File: rtl/ptsf_pkg.sv
package ptsf_pkg;

    // Record field widths
    localparam int TAG_W  = 16;
    localparam int SEC_W  = 48;
    localparam int NS_W   = 32;
    localparam int CID_W  = 64;
    localparam int PORT_W = 16;
    localparam int SEQ_W  = 16;
    localparam int WORD_W = 16;

    // Words per field and their start index in the read sequence
    localparam int SEC_WORDS  = SEC_W / WORD_W;
    localparam int NS_WORDS   = NS_W / WORD_W;
    localparam int CID_WORDS  = CID_W / WORD_W;
    localparam int SEC_FIRST  = 1;
    localparam int NS_FIRST   = SEC_FIRST + SEC_WORDS;
    localparam int CID_FIRST  = NS_FIRST + NS_WORDS;
    localparam int PORT_IDX   = CID_FIRST + CID_WORDS;
    localparam int SEQ_IDX    = PORT_IDX + 1;
    localparam int REC_WORDS  = SEQ_IDX + 1;

    // Status register layout
    localparam int POS_W     = 5;
    localparam int DROP_W    = 4;
    localparam int EN_BIT    = 15;
    localparam int POS_LSB   = 8;
    localparam int DROP_LSB  = 4;

    localparam logic ADDR_STAT = 1'b0;
    localparam logic ADDR_DATA = 1'b1;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [SEC_W-1:0]  sec;
        logic [NS_W-1:0]   nsec;
        logic [CID_W-1:0]  clkid;
        logic [PORT_W-1:0] port;
        logic [SEQ_W-1:0]  seq;
    } ts_rec_t;

    typedef enum logic [1:0] {
        RD_OFF   = 2'd0,
        RD_EMPTY = 2'd1,
        RD_HEAD  = 2'd2,
        RD_MID   = 2'd3
    } rd_state_e;

endpackage

// File: rtl/ptsf_store.sv
module ptsf_store
    import ptsf_pkg::*;
#(
    parameter int DEPTH = 90,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  ts_rec_t          push_rec,
    input  logic             pop,
    output ts_rec_t          head_rec,
    output logic [CNT_W-1:0] count,
    output logic             full
);

    ts_rec_t          mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_rec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign head_rec = mem[rd_ptr];
    assign full     = (count == CNT_W'(DEPTH));

endmodule

// File: rtl/ptsf_word_mux.sv
module ptsf_word_mux
    import ptsf_pkg::*;
(
    input  ts_rec_t            rec,
    input  logic [POS_W-1:0]   idx,
    output logic [WORD_W-1:0]  word
);

    logic [WORD_W-1:0] w [REC_WORDS];

    assign w[0] = rec.tag;

    for (genvar g = 0; g < SEC_WORDS; g++) begin : g_sec
        assign w[SEC_FIRST + g] = rec.sec[WORD_W*(SEC_WORDS-1-g) +: WORD_W];
    end

    for (genvar g = 0; g < NS_WORDS; g++) begin : g_ns
        assign w[NS_FIRST + g] = rec.nsec[WORD_W*(NS_WORDS-1-g) +: WORD_W];
    end

    for (genvar g = 0; g < CID_WORDS; g++) begin : g_cid
        assign w[CID_FIRST + g] = rec.clkid[WORD_W*(CID_WORDS-1-g) +: WORD_W];
    end

    assign w[PORT_IDX] = rec.port;
    assign w[SEQ_IDX]  = rec.seq;

    always_comb begin
        word = '0;
        for (int i = 0; i < REC_WORDS; i++) begin
            if (idx == POS_W'(i)) word = w[i];
        end
    end

endmodule

// File: rtl/ptsf_reader.sv
module ptsf_reader
    import ptsf_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_nxt,
    input  logic             push_now,
    input  logic             data_rd,
    input  logic [CNT_W-1:0] count,
    output logic [POS_W-1:0] pos,
    output logic             pop,
    output logic             has_rec
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(REC_WORDS - 1);

    rd_state_e state, state_nxt;
    logic      last_word;
    logic      more_left;

    assign last_word = (pos == LAST_POS);
    assign more_left = (count > CNT_W'(1)) || push_now;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RD_OFF;
        else        state <= state_nxt;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            RD_OFF:   state_nxt = RD_EMPTY;                         // EN_SET
            RD_EMPTY: if (push_now) state_nxt = RD_HEAD;            // REC_ARRIVE
            RD_HEAD:  if (data_rd)  state_nxt = RD_MID;             // FIRST_READ
            RD_MID:   if (data_rd && last_word)                     // LAST_READ
                          state_nxt = more_left ? RD_HEAD : RD_EMPTY;
            default:  state_nxt = RD_OFF;
        endcase
        if (!en_nxt) state_nxt = RD_OFF;                            // DISABLE
    end

    // Outputs
    always_comb begin
        has_rec = (state == RD_HEAD) || (state == RD_MID);
        pop     = has_rec && data_rd && last_word;
    end

    // Word position counter
    always_ff @(posedge clk) begin
        if (!rst_n || !en_nxt) begin
            pos <= '0;
        end else if (has_rec && data_rd) begin
            pos <= last_word ? '0 : pos + POS_W'(1);           // NEXT_WORD / wrap
        end
    end

endmodule

// File: rtl/ptp_ts_fifo.sv
module ptp_ts_fifo
    import ptsf_pkg::*;
#(
    parameter int DEPTH = 90
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_valid,
    input  logic [TAG_W-1:0]    cap_tag,
    input  logic [SEC_W-1:0]    cap_sec,
    input  logic [NS_W-1:0]     cap_nsec,
    input  logic [CID_W-1:0]    cap_clkid,
    input  logic [PORT_W-1:0]   cap_port,
    input  logic [SEQ_W-1:0]    cap_seq,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic                bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    output logic                fifo_not_empty
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [DROP_W-1:0] DROP_MAX = '1;

    logic              en_q;
    logic              en_nxt;
    logic              wr_stat;
    logic              data_rd;
    logic              push_now;
    logic              drop_now;
    logic              st_full;
    logic [CNT_W-1:0]  st_count;
    logic              rd_pop;
    logic              rd_has;
    logic [POS_W-1:0]  rd_pos;
    logic [DROP_W-1:0] drop_q;
    ts_rec_t           cap_rec;
    ts_rec_t           head_rec;
    logic [WORD_W-1:0] head_word;
    logic [WORD_W-1:0] stat_word;
    logic              wdata_unused;

    assign wdata_unused = ^bus_wdata;

    assign cap_rec  = '{tag: cap_tag, sec: cap_sec, nsec: cap_nsec,
                        clkid: cap_clkid, port: cap_port, seq: cap_seq};
    assign wr_stat  = bus_wr && (bus_addr == ADDR_STAT);
    assign data_rd  = bus_rd && (bus_addr == ADDR_DATA);
    assign en_nxt   = wr_stat ? bus_wdata[EN_BIT] : en_q;
    assign push_now = cap_valid && en_q && !st_full;
    assign drop_now = cap_valid && en_q && st_full;

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !en_nxt)                 drop_q <= '0;
        else if (drop_now && drop_q != DROP_MAX) drop_q <= drop_q + DROP_W'(1);
    end

    ptsf_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (!en_nxt),
        .push     (push_now),
        .push_rec (cap_rec),
        .pop      (rd_pop),
        .head_rec (head_rec),
        .count    (st_count),
        .full     (st_full)
    );

    ptsf_reader #(.CNT_W(CNT_W)) u_reader (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_nxt   (en_nxt),
        .push_now (push_now),
        .data_rd  (data_rd),
        .count    (st_count),
        .pos      (rd_pos),
        .pop      (rd_pop),
        .has_rec  (rd_has)
    );

    ptsf_word_mux u_mux (
        .rec  (head_rec),
        .idx  (rd_pos),
        .word (head_word)
    );

    always_comb begin
        stat_word = '0;
        stat_word[EN_BIT] = en_q;
        stat_word[POS_LSB +: POS_W] = rd_pos;
        stat_word[DROP_LSB +: DROP_W] = drop_q;
    end

    assign bus_rdata      = (bus_addr == ADDR_STAT) ? stat_word
                          : (rd_has ? head_word : '0);
    assign fifo_not_empty = rd_has;

endmodule

// File: rtl/ptp_ts_fifo_chk.sv
module ptp_ts_fifo_chk
    import ptsf_pkg::*;
#(
    parameter int DEPTH = 90,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_q,
    input logic [POS_W-1:0]  pos,
    input logic [DROP_W-1:0] drop,
    input logic [CNT_W-1:0]  count,
    input logic              full,
    input logic              not_empty,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              bus_addr,
    input logic              cap_valid
);

    a_r3_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
        pos < POS_W'(REC_WORDS));

    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (not_empty && bus_rd && bus_addr && pos == POS_W'(REC_WORDS - 1))
        |=> pos == '0);

    a_r7_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!not_empty && bus_rd && bus_addr && !bus_wr) |=> $stable(pos));

    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    a_r6_drop_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && cap_valid && full && drop != '1 && !bus_wr)
        |=> drop == $past(drop) + DROP_W'(1));

    a_r6_drop_mono: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && $past(en_q)) |-> drop >= $past(drop));

    a_r4_flag_match: assert property (@(posedge clk) disable iff (!rst_n)
        not_empty == (count != '0));

    a_r8_off_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (count == '0 && pos == '0 && drop == '0));

endmodule

bind ptp_ts_fifo ptp_ts_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_q      (en_q),
    .pos       (rd_pos),
    .drop      (drop_q),
    .count     (st_count),
    .full      (st_full),
    .not_empty (fifo_not_empty),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .cap_valid (cap_valid)
);

// File: tb/ptp_ts_fifo_bench.sv
module ptp_ts_fifo_bench;

    localparam int QDEPTH = 90;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cap_valid = 1'b0;
    logic [15:0]  cap_tag = '0;
    logic [47:0]  cap_sec = '0;
    logic [31:0]  cap_nsec = '0;
    logic [63:0]  cap_clkid = '0;
    logic [15:0]  cap_port = '0;
    logic [15:0]  cap_seq = '0;
    logic         bus_rd = 1'b0;
    logic         bus_wr = 1'b0;
    logic         bus_addr = 1'b0;
    logic [15:0]  bus_wdata = '0;
    logic [15:0]  bus_rdata;
    logic         fifo_not_empty;

    always #10 clk = ~clk;

    ptp_ts_fifo #(.DEPTH(QDEPTH)) u_ptp_ts_fifo (.*);

    // Reference model
    logic [191:0] q[$];
    int  m_pos = 0;
    int  m_drop = 0;
    bit  m_en = 1'b0;
    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    function automatic logic [15:0] word_of(logic [191:0] r, int i);
        return r[191 - 16*i -: 16];
    endfunction

    function automatic logic [191:0] mkrec(int n);
        logic [191:0] r;
        r = '0;
        for (int i = 0; i < 12; i++) r[191 - 16*i -: 16] = {4'(i), 12'(n)};
        r[191 -: 16] = {13'(n), 3'(1 + n % 4)};
        return r;
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(bit cap, logic [191:0] rec, bit rd, bit wr, bit addr,
                        logic [15:0] wd, string req);
        logic [15:0] exp_rd;
        bit          exp_ne;
        int          size_before;
        bit          en_n;
        @(negedge clk);
        cap_valid = cap;
        {cap_tag, cap_sec, cap_nsec, cap_clkid, cap_port, cap_seq} = rec;
        bus_rd = rd; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
        #1;
        exp_ne = m_en && (q.size() > 0);
        if (!addr) exp_rd = {m_en, 2'b00, 5'(m_pos), 4'(m_drop), 4'b0000};
        else       exp_rd = exp_ne ? word_of(q[0], m_pos) : 16'h0000;
        check(req, bus_rdata, exp_rd);
        check({req, " flag"}, {15'd0, fifo_not_empty}, {15'd0, exp_ne});
        @(posedge clk);
        size_before = q.size();
        en_n = (wr && !addr) ? wd[15] : m_en;
        if (rd && addr && exp_ne) begin
            m_pos++;
            if (m_pos == 12) begin
                m_pos = 0;
                void'(q.pop_front());
            end
        end
        if (cap && m_en) begin
            if (size_before >= QDEPTH) begin
                if (m_drop < 15) m_drop++;
            end else begin
                q.push_back(rec);
            end
        end
        if (!en_n) begin
            q.delete();
            m_pos = 0;
            m_drop = 0;
        end
        m_en = en_n;
    endtask

    task automatic idle(string req);             step(0, '0, 0, 0, 0, '0, req); endtask
    task automatic rd_data(string req);          step(0, '0, 1, 0, 1, '0, req); endtask
    task automatic capture(int n, string req);   step(1, mkrec(n), 0, 0, 0, '0, req); endtask
    task automatic wr_stat(logic [15:0] v, string req); step(0, '0, 0, 1, 0, v, req); endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state on both registers
        idle("R1 status after reset");
        step(0, '0, 0, 0, 1, '0, "R1 data after reset");

        // R5: strobe while disabled is ignored
        capture(7, "R5 capture while off");
        idle("R5 status after ignored capture");
        step(0, '0, 0, 0, 1, '0, "R5 data still zero");

        wr_stat(16'h8000, "R5 enable");
        idle("R5 enable visible");

        // R7: empty reads return zero, position unchanged
        rd_data("R7 empty read");
        rd_data("R7 empty read again");
        idle("R7 position after empty reads");

        // R2, R3, R10: three records, reads interleaved with status
        capture(1, "R4 capture first");
        capture(2, "R4 capture second");
        capture(3, "R4 capture third");
        for (int w = 0; w < 12; w++) begin
            rd_data("R2 word order rec1");
            idle("R3 position after read");
        end
        // R9: data register write ignored, status read side-effect free
        step(0, '0, 0, 1, 1, 16'hFFFF, "R9 data write ignored");
        idle("R9 status read");
        idle("R9 status read repeated");
        for (int w = 0; w < 24; w++) rd_data("R10 capture order");
        idle("R4 flag low after drain");
        rd_data("R7 read after drain");

        // R6: fill to depth, overflow saturates the discard count
        for (int n = 0; n < QDEPTH; n++) capture(100 + n, "R6 fill");
        idle("R6 full status");
        for (int n = 0; n < 18; n++) capture(300 + n, "R6 overflow");
        idle("R6 drop saturated");
        // remove while full with coincident capture: still dropped
        wr_stat(16'h0000, "R8 clear");
        wr_stat(16'h8000, "R8 re-enable");
        for (int n = 0; n < QDEPTH; n++) capture(500 + n, "R6 refill");
        for (int w = 0; w < 11; w++) rd_data("R6 read first record");
        step(1, mkrec(900), 1, 0, 1, '0, "R6 last word with capture while full");
        idle("R6 count after coincident drop");
        for (int w = 0; w < 12 * (QDEPTH - 1); w++) rd_data("R10 drain full queue");
        idle("R4 empty after full drain");

        // R8: disable part-way through a record
        capture(42, "R8 capture");
        capture(43, "R8 capture");
        for (int w = 0; w < 5; w++) rd_data("R3 partial read");
        idle("R3 mid-record position");
        wr_stat(16'h0000, "R8 disable mid record");
        idle("R8 flushed status");
        step(0, '0, 0, 0, 1, '0, "R8 data after flush");
        wr_stat(16'h8000, "R8 re-enable");
        idle("R8 still empty");
        capture(44, "R8 capture after flush");
        rd_data("R2 first word after flush");
        idle("R3 position one");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule